// File: doc/BRIEF.md
# Routing Matrix Configuration Controller

This block is the digital control logic that configures a routing matrix with 16 outputs and 16 inputs. Each output owns a 5-bit configuration word. The low four bits choose which input drives that output. The top bit turns the output on or off. Words are first collected in a staging register, and a level-sensitive update input then moves them into a live latch bank. The live words are decoded into 256 crosspoint enables and 16 output enables for the analog matrix.

The staging register can be loaded in two ways. In serial mode it works as one long shift chain. Its far end is brought out on a pin, so that several controllers can be cascaded and loaded from a single stream. In parallel mode, an address picks one output and a 5-bit value is written into that output's slice only. The control strobe and the update input come from off-chip. Each passes through a two-flop synchronizer on the system clock, and loading happens on the detected falling edge of the synchronized strobe. The mode, chip-enable, serial data, address and data inputs must be held steady from before the strobe falls until the load has been taken, which is three system clocks after the fall.

Top module: `xpt_route_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the staging register and the live bank are all zero. As a result, every `out_en_o` bit, every `xpt_en_o` bit and `sdata_o` read 0 until new configuration arrives.
- R2: When `ser_mode_i`=1 and `ce_i`=1, each falling edge of `strobe_i` shifts `sdata_i` into the staging register. Word bit b of output k sits at staging index k*5+b. The newest bit enters index 0 (output 0, bit 0), and every other bit moves up one index. After 80 strobes, the first bit sent sits in output 15, bit 4.
- R3: `sdata_o` always shows staging index 79 (output 15, bit 4). A bit shifted in therefore appears on `sdata_o` after 80 strobes, which allows controllers to be cascaded.
- R4: When `ser_mode_i`=0 and `ce_i`=1, a falling strobe writes `pdata_i` into the slice of the output named by `paddr_i`. The other 75 staging bits keep their values.
- R5: While `ce_i`=0, strobes have no effect on the staging register, in either mode.
- R6: While `upd_i` is low, the live bank follows the staging register.
- R7: While `upd_i` is high, the live bank holds, even when the staging register changes.
- R8: When bit 4 of an output's live word is 1, `out_en_o[k]`=1 and exactly one crosspoint of that output is asserted: `xpt_en_o[k*16+s]`, where s is bits 3..0 of the word.
- R9: When bit 4 of an output's live word is 0, `out_en_o[k]`=0 and none of that output's 16 crosspoint lines is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; disables all outputs |
| ser_mode_i | input | 1 | Load mode: 1 serial shift, 0 parallel addressed write |
| ce_i | input | 1 | Chip enable; strobes load only when high |
| strobe_i | input | 1 | Off-chip control strobe; loads on its falling edge |
| upd_i | input | 1 | Update level: low passes staging to live, high holds live |
| sdata_i | input | 1 | Serial configuration bit |
| paddr_i | input | 4 | Output address for parallel writes |
| pdata_i | input | 5 | Configuration word for parallel writes |
| sdata_o | output | 1 | Far end of the shift chain, for cascading |
| xpt_en_o | output | 256 | Crosspoint enables, index output*16+input |
| out_en_o | output | 16 | Per-output enables |

## Verification
Each staging bit is visible at the ports in two ways. One is through `sdata_o`, after enough further shifts. The other is through the crosspoint and output-enable pins, about one clock after the update goes transparent. A corrupted slice therefore shows as a wrong or missing crosspoint within four to six system clocks of the strobe, or of the update falling. A live bank that fails to hold appears on `xpt_en_o` as soon as a write is made behind a held update. A wrong shift direction or bit order moves the enables to the wrong output after a full 80-bit load. Loads that leak past a low chip enable appear as changed crosspoints on the next check.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   typedef enum logic {
      LOAD_PAR = 1'b0,
      LOAD_SER = 1'b1
   } load_mode_e;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("xpt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

   // R6
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chain_q[STAGES-2]) == chain_q[STAGES-1] || !$past(rst_n));
endmodule

// File: rtl/xpt_stage.sv
module xpt_stage
   import xpt_pkg::*;
#(
   parameter int N_OUT  = 16,
   parameter int WORD_W = 5,
   parameter int ADDR_W = 4,
   localparam int TOT   = N_OUT * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_evt_i,
   input  load_mode_e        mode_i,
   input  logic              sdata_i,
   input  logic [ADDR_W-1:0] paddr_i,
   input  logic [WORD_W-1:0] pdata_i,
   output logic [TOT-1:0]    stage_o,
   output logic              sdata_o
);
   if (TOT < 2) begin : g_bad
      $error("xpt_stage: staging register too short");
   end

   logic [TOT-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (ld_evt_i) begin
         if (mode_i == LOAD_SER) begin
            stage_q <= {stage_q[TOT-2:0], sdata_i};
         end else if (int'(paddr_i) < N_OUT) begin
            stage_q[int'(paddr_i)*WORD_W +: WORD_W] <= pdata_i;
         end
      end
   end

   assign stage_o = stage_q;
   assign sdata_o = stage_q[TOT-1];

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_evt_i |=> $stable(stage_q));

   // R2
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_evt_i && mode_i == LOAD_SER) |=>
         (stage_q[0] == $past(sdata_i) && stage_q[TOT-1:1] == $past(stage_q[TOT-2:0])));

   for (genvar g = 0; g < N_OUT; g++) begin : g_slice
      // R4
      other_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_evt_i && mode_i == LOAD_PAR && int'(paddr_i) != g) |=>
            $stable(stage_q[g*WORD_W +: WORD_W]));
      // R4
      addr_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_evt_i && mode_i == LOAD_PAR && int'(paddr_i) == g) |=>
            stage_q[g*WORD_W +: WORD_W] == $past(pdata_i));
   end
endmodule

// File: rtl/xpt_live.sv
module xpt_live #(
   parameter int TOT = 80
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold_i,
   input  logic [TOT-1:0] stage_i,
   output logic [TOT-1:0] live_o
);
   logic [TOT-1:0] live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       live_q <= '0;
      else if (!hold_i) live_q <= stage_i;
   end

   assign live_o = live_q;

   // R7
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(live_q));

   // R6
   live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> live_q == $past(stage_i));
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
   parameter int N_OUT = 16,
   parameter int N_IN  = 16,
   parameter int SEL_W = 4,
   localparam int WORD_W = SEL_W + 1,
   localparam int TOT    = N_OUT * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TOT-1:0]     live_i,
   output logic [N_OUT*N_IN-1:0] xpt_o,
   output logic [N_OUT-1:0]   oen_o
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic             en;
      logic [SEL_W-1:0] sel;
      assign en       = live_i[o*WORD_W + SEL_W];
      assign sel      = live_i[o*WORD_W +: SEL_W];
      assign oen_o[o] = en;

      for (genvar i = 0; i < N_IN; i++) begin : g_in
         assign xpt_o[o*N_IN + i] = en && (int'(sel) == i);
      end

      // R9
      off_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !oen_o[o] |-> xpt_o[o*N_IN +: N_IN] == '0);
      // R8
      on_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (oen_o[o] && int'(live_i[o*WORD_W +: SEL_W]) < N_IN) |->
            $countones(xpt_o[o*N_IN +: N_IN]) == 1);
      // R8
      row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(xpt_o[o*N_IN +: N_IN]));
   end
endmodule

// File: rtl/xpt_route_ctrl.sv
module xpt_route_ctrl
   import xpt_pkg::*;
#(
   parameter int N_OUT       = 16,
   parameter int N_IN        = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W  = $clog2(N_IN),
   localparam int WORD_W = SEL_W + 1,
   localparam int ADDR_W = $clog2(N_OUT),
   localparam int TOT    = N_OUT * WORD_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_mode_i,
   input  logic                     ce_i,
   input  logic                     strobe_i,
   input  logic                     upd_i,
   input  logic                     sdata_i,
   input  logic [ADDR_W-1:0]        paddr_i,
   input  logic [WORD_W-1:0]        pdata_i,
   output logic                     sdata_o,
   output logic [N_OUT*N_IN-1:0]    xpt_en_o,
   output logic [N_OUT-1:0]         out_en_o
);
   if (N_OUT < 2 || N_IN < 2) begin : g_bad_dims
      $error("xpt_route_ctrl: N_OUT and N_IN must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xpt_route_ctrl: SYNC_STAGES must be at least 2");
   end

   logic           strb_s, strb_d, upd_s, ld_evt;
   logic [TOT-1:0] stage, live;

   xpt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strb (
      .clk(clk), .rst_n(rst_n), .d_i(strobe_i), .q_o(strb_s));

   xpt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_upd (
      .clk(clk), .rst_n(rst_n), .d_i(upd_i), .q_o(upd_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_d <= 1'b0;
      else        strb_d <= strb_s;
   end

   assign ld_evt = strb_d && !strb_s && ce_i;

   xpt_stage #(.N_OUT(N_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .ld_evt_i(ld_evt),
      .mode_i(load_mode_e'(ser_mode_i)), .sdata_i(sdata_i),
      .paddr_i(paddr_i), .pdata_i(pdata_i),
      .stage_o(stage), .sdata_o(sdata_o));

   xpt_live #(.TOT(TOT)) u_live (
      .clk(clk), .rst_n(rst_n), .hold_i(upd_s),
      .stage_i(stage), .live_o(live));

   xpt_decode #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) u_decode (
      .clk(clk), .rst_n(rst_n), .live_i(live),
      .xpt_o(xpt_en_o), .oen_o(out_en_o));

   // R1
   reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (out_en_o == '0 && xpt_en_o == '0 && !sdata_o));

   // R3
   chain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_evt |=> $stable(sdata_o));

   // R5
   ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_i |-> !ld_evt);
endmodule

// File: tb/xpt_route_ctrl_tb.sv
module xpt_route_ctrl_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_mode_i = 1'b0, ce_i = 1'b0, strobe_i = 1'b0, upd_i = 1'b1, sdata_i = 1'b0;
   logic [3:0]   paddr_i = '0;
   logic [4:0]   pdata_i = '0;
   logic         sdata_o;
   logic [255:0] xpt_en_o;
   logic [15:0]  out_en_o;

   int n_chk = 0;
   int n_err = 0;
   logic [79:0] m_stage = '0;
   logic [79:0] m_live  = '0;

   always #4 clk = ~clk;

   xpt_route_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ser_mode_i(ser_mode_i), .ce_i(ce_i),
      .strobe_i(strobe_i), .upd_i(upd_i), .sdata_i(sdata_i),
      .paddr_i(paddr_i), .pdata_i(pdata_i), .sdata_o(sdata_o),
      .xpt_en_o(xpt_en_o), .out_en_o(out_en_o));

   function automatic logic [255:0] exp_xpt(logic [79:0] lv);
      logic [255:0] r = '0;
      for (int k = 0; k < 16; k++)
         if (lv[k*5+4]) r[k*16 + int'(lv[k*5 +: 4])] = 1'b1;
      return r;
   endfunction

   function automatic logic [15:0] exp_oen(logic [79:0] lv);
      logic [15:0] r;
      for (int k = 0; k < 16; k++) r[k] = lv[k*5+4];
      return r;
   endfunction

   task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_all(string tag);
      chk({tag, " xpt"},  xpt_en_o, exp_xpt(m_live));
      chk({tag, " oen"},  {240'b0, out_en_o}, {240'b0, exp_oen(m_live)});
      chk({tag, " sout"}, {255'b0, sdata_o}, {255'b0, m_stage[79]});
   endtask

   task automatic pulse();
      strobe_i = 1'b1;
      settle(4);
      strobe_i = 1'b0;
      settle(6);
   endtask

   task automatic ser_bit(logic b);
      ser_mode_i = 1'b1;
      sdata_i    = b;
      pulse();
      if (ce_i) m_stage = {m_stage[78:0], b};
      if (!upd_i) m_live = m_stage;
   endtask

   task automatic par_wr(int a, logic [4:0] d);
      ser_mode_i = 1'b0;
      paddr_i    = 4'(a);
      pdata_i    = d;
      pulse();
      if (ce_i) m_stage[a*5 +: 5] = d;
      if (!upd_i) m_live = m_stage;
   endtask

   task automatic set_upd(logic v);
      upd_i = v;
      settle(6);
      if (!v) m_live = m_stage;
   endtask

   task automatic t_reset();
      settle(4);
      chk_all("R1 reset");
      rst_n = 1'b1;
      settle(4);
      chk_all("R1 after release");
   endtask

   task automatic t_serial();
      logic [79:0] tgt;
      for (int k = 0; k < 16; k++) begin
         tgt[k*5 +: 4] = 4'((k*7 + 3) % 16);
         tgt[k*5+4]    = (k % 3) != 0;
      end
      ce_i = 1'b1;
      for (int j = 79; j >= 0; j--) ser_bit(tgt[j]);
      chk_all("R7 held during serial load");
      chk({"R2 model"}, {176'b0, m_stage}, {176'b0, tgt});
      set_upd(1'b0);
      chk_all("R2 R8 R9 serial routing");
   endtask

   task automatic t_daisy();
      for (int j = 0; j < 5; j++) begin
         ser_bit(1'b0);
         chk_all("R3 chain out");
      end
      for (int j = 0; j < 80; j++) ser_bit(1'b1);
      chk_all("R3 all ones after 80");
   endtask

   task automatic t_parallel();
      par_wr(5, 5'b1_1001);
      chk_all("R4 R8 write output 5");
      par_wr(0, 5'b0_0110);
      chk_all("R4 R9 disable output 0");
      par_wr(15, 5'b1_0000);
      chk_all("R4 R3 write output 15");
   endtask

   task automatic t_ce();
      ce_i = 1'b0;
      par_wr(3, 5'b0_0000);
      chk_all("R5 parallel ignored");
      ser_bit(1'b0);
      chk_all("R5 serial ignored");
      ce_i = 1'b1;
   endtask

   task automatic t_hold();
      set_upd(1'b1);
      par_wr(7, 5'b1_0010);
      par_wr(9, 5'b0_0001);
      chk_all("R7 live holds");
      set_upd(1'b0);
      chk_all("R6 transparent again");
   endtask

   task automatic t_reset_mid();
      rst_n = 1'b0;
      settle(3);
      m_stage = '0;
      m_live  = '0;
      chk_all("R1 mid reset");
      rst_n = 1'b1;
      settle(8);
      chk_all("R1 staging cleared");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_serial();
      t_daisy();
      t_parallel();
      t_ce();
      t_hold();
      t_reset_mid();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule